// File: doc/BRIEF.md
# Indexed-Access Interrupt Controller Core

This block gathers level-sensitive interrupt sources and presents each processor with one IRQ line, one FIQ line and a claim value naming the source it should service. Software never writes bitmasks. To change a source's global enable or a per-processor mask, it writes the source's number to a dedicated "set" or "clear" register. An index at or beyond the implemented count is ignored. Each source also has a routing word that sends it to any mix of processors' IRQ or FIQ lines.

Register accesses carry a processor select, so one address map serves both global and per-processor registers. The lowest sources are private to each processor: each processor has its own pending inputs for those numbers, and a cause register shows them as a bitmask. The remaining sources are shared. A source is offered to a processor only when all of these hold:
- the controller is on;
- the source is pending;
- the source is globally enabled;
- the source is unmasked for that processor;
- the source is routed to that processor.

Priority is fixed: the lowest number wins. A per-processor priority register is storage only.

Top module: `icIndexedCore`

## Requirements
- R1: After reset the controller is off, every source is disabled and masked for every processor, every routing word is zero and every priority register is zero. Both output vectors are low and the claim register (offset 0x44) reads 0x3FF.
- R2: The control register (offset 0x000) reads the implemented source count in bits [11:2] and the on bit in bit 0. Writing bit 0 turns the controller on or off. While it is off, all IRQ and FIQ outputs are low and claims read 0x3FF.
- R3: Writing index N (write data bits [9:0]) to offset 0x030 enables source N, and writing N to offset 0x034 disables it. No other source changes.
- R4: Writing N to offset 0x048 masks source N for the selected processor only, and writing N to offset 0x04C unmasks it for that processor only.
- R5: The routing word of source N sits at offset 0x100 + 4*N. Bit c routes the source to processor c's IRQ line and bit 8+c routes it to processor c's FIQ line. The word reads back with all other bits zero.
- R6: The claim register (offset 0x44) returns, in bits [9:0] with bits [31:10] zero, the lowest-numbered source that is pending, enabled, unmasked for the selected processor and routed to that processor's IRQ line. When no source qualifies it returns 0x3FF.
- R7: irqOut[c] is high exactly when processor c's claim value differs from 0x3FF.
- R8: fiqOut[c] is high exactly when the controller is on and some source is pending, enabled, unmasked for c and routed to c's FIQ line.
- R9: Sources below NUM_PRIV take their pending state from the selected processor's own slice of privPend, bit c*NUM_PRIV+n for source n. Source NUM_PRIV+k takes it from sharedPend bit k. The cause register (offset 0x010) reads the selected processor's private pending bits as a bitmask.
- R10: An index write to offset 0x030, 0x034, 0x048 or 0x04C whose index (write data bits [9:0]) is at or above the source count changes nothing. Indices are not reduced modulo the count.
- R11: Each processor has a priority register at offset 0x040 (PRIO_W bits, read/write, reset 0). It has no effect on claim selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cpuSel | input | CS_W | Processor whose per-processor registers the access targets |
| addr | input | ADDR_W | Byte address of the register access |
| wrEn | input | 1 | Write strobe; reads are combinational and free of side effects |
| wData | input | 32 | Write data |
| rData | output | 32 | Read data for addr/cpuSel |
| sharedPend | input | NUM_SRC-NUM_PRIV | Pending levels of the shared sources |
| privPend | input | NUM_CPU*NUM_PRIV | Per-processor pending levels of the private sources |
| irqOut | output | NUM_CPU | IRQ request per processor |
| fiqOut | output | NUM_CPU | FIQ request per processor |

## Verification
The claim path is exercised with several cases:
- two eligible sources, where the lower one must win;
- a source that is pending and enabled but still masked;
- a source unmasked for one processor only;
- a source disabled while another remains eligible;
- a private source pending on one processor and not on the other.

Together these separate errors in the enable, mask, routing and per-processor pending terms. Out-of-range indices are chosen so that a decoder reducing them modulo the source count would hit a live source and visibly change a claim. FIQ routing is tested with a source that is routed but still masked, then unmasked, so that the FIQ line is shown to honour the mask.

// File: rtl/icPkg.sv
package icPkg;
  localparam int IDX_W = 10;
  localparam int CPU_W = 3;
  localparam logic [IDX_W-1:0] NONE_CODE = 10'h3FF;

  localparam int OFF_CTRL   = 'h000;
  localparam int OFF_CAUSE  = 'h010;
  localparam int OFF_SETEN  = 'h030;
  localparam int OFF_CLREN  = 'h034;
  localparam int OFF_PRIO   = 'h040;
  localparam int OFF_ACK    = 'h044;
  localparam int OFF_SETMSK = 'h048;
  localparam int OFF_CLRMSK = 'h04C;
  localparam int ROUTE_BASE = 'h100;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_CAUSE, RD_PRIO, RD_ACK, RD_ROUTE
  } rdSel_e;

  typedef struct packed {
    logic             setEn;
    logic             clrEn;
    logic             setMsk;
    logic             clrMsk;
    logic             wrCtrl;
    logic             wrPrio;
    logic             wrRoute;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] routeIdx;
    logic [CPU_W-1:0] cpu;
    rdSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/icCtrl.sv
module icCtrl
  import icPkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 12,
  localparam int CS_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [CS_W-1:0]   cpuSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wIdx,
  output strobe_t           stb
);
  logic              cpuOk;
  logic              idxOk;
  logic              routeHit;
  logic [ADDR_W-1:0] rOff;

  always_comb begin
    cpuOk    = int'(cpuSel) < NUM_CPU;
    idxOk    = {1'b0, wIdx} < (IDX_W+1)'(NUM_SRC);
    rOff     = addr - ADDR_W'(ROUTE_BASE);
    routeHit = (addr >= ADDR_W'(ROUTE_BASE)) && (rOff[1:0] == 2'b00)
               && (int'(rOff >> 2) < NUM_SRC);

    stb          = '0;
    stb.rdSel    = RD_NONE;
    stb.idx      = wIdx;
    stb.routeIdx = IDX_W'(rOff >> 2);
    stb.cpu      = CPU_W'(cpuSel);

    case (addr)
      ADDR_W'(OFF_CTRL): begin
        stb.rdSel  = RD_CTRL;
        stb.wrCtrl = wrEn;
      end
      ADDR_W'(OFF_SETEN):  stb.setEn  = wrEn && idxOk;
      ADDR_W'(OFF_CLREN):  stb.clrEn  = wrEn && idxOk;
      ADDR_W'(OFF_SETMSK): stb.setMsk = wrEn && idxOk && cpuOk;
      ADDR_W'(OFF_CLRMSK): stb.clrMsk = wrEn && idxOk && cpuOk;
      ADDR_W'(OFF_CAUSE):  if (cpuOk) stb.rdSel = RD_CAUSE;
      ADDR_W'(OFF_ACK):    if (cpuOk) stb.rdSel = RD_ACK;
      ADDR_W'(OFF_PRIO): begin
        if (cpuOk) begin
          stb.rdSel  = RD_PRIO;
          stb.wrPrio = wrEn;
        end
      end
      default: begin
        if (routeHit) begin
          stb.rdSel   = RD_ROUTE;
          stb.wrRoute = wrEn;
        end
      end
    endcase
  end
endmodule

// File: rtl/icPickLow.sv
module icPickLow
  import icPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int s = WIDTH - 1; s >= 0; s--) begin
      if (req[s]) idx = IDX_W'(s);
    end
  end
endmodule

// File: rtl/icDatapath.sv
module icDatapath
  import icPkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CPU  = 2,
  parameter int NUM_PRIV = 4,
  parameter int PRIO_W   = 4,
  localparam int SH_W    = NUM_SRC - NUM_PRIV,
  localparam int PV_W    = NUM_CPU * NUM_PRIV
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [31:0]        wData,
  input  logic [SH_W-1:0]    sharedPend,
  input  logic [PV_W-1:0]    privPend,
  output logic [31:0]        rData,
  output logic [NUM_CPU-1:0] irqOut,
  output logic [NUM_CPU-1:0] fiqOut
);
  logic                 ctrlOn;
  logic [NUM_SRC-1:0]   enReg;
  logic [NUM_SRC-1:0]   mskReg  [NUM_CPU];
  logic [NUM_CPU-1:0]   irqRt   [NUM_SRC];
  logic [NUM_CPU-1:0]   fiqRt   [NUM_SRC];
  logic [PRIO_W-1:0]    prioReg [NUM_CPU];
  logic [IDX_W-1:0]     ackCode [NUM_CPU];
  logic                 unusedBits;

  assign unusedBits = ^wData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlOn <= 1'b0;
      enReg  <= '0;
      for (int c = 0; c < NUM_CPU; c++) begin
        mskReg[c]  <= '1;
        prioReg[c] <= '0;
      end
      for (int s = 0; s < NUM_SRC; s++) begin
        irqRt[s] <= '0;
        fiqRt[s] <= '0;
      end
    end else begin
      if (stb.wrCtrl) ctrlOn <= wData[0];
      for (int s = 0; s < NUM_SRC; s++) begin
        if (stb.setEn && stb.idx == IDX_W'(s)) enReg[s] <= 1'b1;
        if (stb.clrEn && stb.idx == IDX_W'(s)) enReg[s] <= 1'b0;
        if (stb.wrRoute && stb.routeIdx == IDX_W'(s)) begin
          irqRt[s] <= wData[NUM_CPU-1:0];
          fiqRt[s] <= wData[8 +: NUM_CPU];
        end
      end
      for (int c = 0; c < NUM_CPU; c++) begin
        if (stb.cpu == CPU_W'(c)) begin
          if (stb.wrPrio) prioReg[c] <= wData[PRIO_W-1:0];
          for (int s = 0; s < NUM_SRC; s++) begin
            if (stb.setMsk && stb.idx == IDX_W'(s)) mskReg[c][s] <= 1'b1;
            if (stb.clrMsk && stb.idx == IDX_W'(s)) mskReg[c][s] <= 1'b0;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
    logic [NUM_SRC-1:0] pendVec;
    logic [NUM_SRC-1:0] irqReq;
    logic [NUM_SRC-1:0] fiqReq;
    logic               hit;
    logic [IDX_W-1:0]   low;

    assign pendVec = {sharedPend, privPend[c*NUM_PRIV +: NUM_PRIV]};

    always_comb begin
      for (int s = 0; s < NUM_SRC; s++) begin
        irqReq[s] = ctrlOn && pendVec[s] && enReg[s] && !mskReg[c][s] && irqRt[s][c];
        fiqReq[s] = ctrlOn && pendVec[s] && enReg[s] && !mskReg[c][s] && fiqRt[s][c];
      end
    end

    icPickLow #(.WIDTH(NUM_SRC)) uPick (
      .req   (irqReq),
      .found (hit),
      .idx   (low)
    );

    assign ackCode[c] = hit ? low : NONE_CODE;
    assign irqOut[c]  = hit;
    assign fiqOut[c]  = |fiqReq;
  end

  always_comb begin
    rData = '0;
    case (stb.rdSel)
      RD_CTRL: begin
        rData[11:2] = IDX_W'(NUM_SRC);
        rData[0]    = ctrlOn;
      end
      RD_ROUTE: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (stb.routeIdx == IDX_W'(s)) begin
            rData[NUM_CPU-1:0]  = irqRt[s];
            rData[8 +: NUM_CPU] = fiqRt[s];
          end
        end
      end
      RD_CAUSE, RD_PRIO, RD_ACK: begin
        for (int c = 0; c < NUM_CPU; c++) begin
          if (stb.cpu == CPU_W'(c)) begin
            if (stb.rdSel == RD_CAUSE) rData[NUM_PRIV-1:0] = privPend[c*NUM_PRIV +: NUM_PRIV];
            else if (stb.rdSel == RD_PRIO) rData[PRIO_W-1:0] = prioReg[c];
            else rData[IDX_W-1:0] = ackCode[c];
          end
        end
      end
      default: rData = '0;
    endcase
  end
endmodule

// File: rtl/icIndexedCore.sv
module icIndexedCore
  import icPkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CPU  = 2,
  parameter int NUM_PRIV = 4,
  parameter int PRIO_W   = 4,
  parameter int ADDR_W   = 12,
  localparam int CS_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SH_W    = NUM_SRC - NUM_PRIV,
  localparam int PV_W    = NUM_CPU * NUM_PRIV
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CS_W-1:0]    cpuSel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [31:0]        wData,
  output logic [31:0]        rData,
  input  logic [SH_W-1:0]    sharedPend,
  input  logic [PV_W-1:0]    privPend,
  output logic [NUM_CPU-1:0] irqOut,
  output logic [NUM_CPU-1:0] fiqOut
);
  strobe_t stb;

  icCtrl #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .ADDR_W  (ADDR_W)
  ) uCtrl (
    .cpuSel (cpuSel),
    .addr   (addr),
    .wrEn   (wrEn),
    .wIdx   (wData[IDX_W-1:0]),
    .stb    (stb)
  );

  icDatapath #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CPU  (NUM_CPU),
    .NUM_PRIV (NUM_PRIV),
    .PRIO_W   (PRIO_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wData      (wData),
    .sharedPend (sharedPend),
    .privPend   (privPend),
    .rData      (rData),
    .irqOut     (irqOut),
    .fiqOut     (fiqOut)
  );
endmodule

// File: rtl/icIndexedCoreChk.sv
module icIndexedCoreChk #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CPU  = 2,
  parameter int NUM_PRIV = 4,
  parameter int ADDR_W   = 12,
  localparam int CS_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SH_W    = NUM_SRC - NUM_PRIV,
  localparam int PV_W    = NUM_CPU * NUM_PRIV
) (
  input logic               clk,
  input logic               rstN,
  input logic [CS_W-1:0]    cpuSel,
  input logic [ADDR_W-1:0]  addr,
  input logic               wrEn,
  input logic [31:0]        wData,
  input logic [31:0]        rData,
  input logic [SH_W-1:0]    sharedPend,
  input logic [PV_W-1:0]    privPend,
  input logic [NUM_CPU-1:0] irqOut,
  input logic [NUM_CPU-1:0] fiqOut
);
  logic unusedChk;
  logic idxWrite;
  logic badIdx;
  logic ackRead;

  assign unusedChk = ^wData[31:10];
  assign idxWrite  = wrEn && (addr == ADDR_W'('h030) || addr == ADDR_W'('h034)
                              || addr == ADDR_W'('h048) || addr == ADDR_W'('h04C));
  assign badIdx    = {1'b0, wData[9:0]} >= 11'(NUM_SRC);
  assign ackRead   = !wrEn && addr == ADDR_W'('h044) && int'(cpuSel) < NUM_CPU;

  // R2: turning the controller off silences every output line
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0) && !wData[0]) |=> (irqOut == '0 && fiqOut == '0));

  // R6: a claim value is either the none code or a valid source, upper bits clear
  a_r6_ack_code: assert property (@(posedge clk) disable iff (!rstN)
    ackRead |-> (rData[31:10] == '0 && (rData[9:0] == 10'h3FF || int'(rData[9:0]) < NUM_SRC)));

  // R7: the IRQ line of the reading processor agrees with its claim value
  a_r7_irq_ack: assert property (@(posedge clk) disable iff (!rstN)
    ackRead |-> (irqOut[cpuSel] == (rData[9:0] != 10'h3FF)));

  // R10: an out-of-range index write leaves the outputs as they were
  a_r10_bad_idx: assert property (@(posedge clk) disable iff (!rstN)
    (idxWrite && badIdx) |=>
      (!($stable(sharedPend) && $stable(privPend)) || ($stable(irqOut) && $stable(fiqOut))));
endmodule

bind icIndexedCore icIndexedCoreChk #(
  .NUM_SRC  (NUM_SRC),
  .NUM_CPU  (NUM_CPU),
  .NUM_PRIV (NUM_PRIV),
  .ADDR_W   (ADDR_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuSel     (cpuSel),
  .addr       (addr),
  .wrEn       (wrEn),
  .wData      (wData),
  .rData      (rData),
  .sharedPend (sharedPend),
  .privPend   (privPend),
  .irqOut     (irqOut),
  .fiqOut     (fiqOut)
);

// File: tb/tb_icIndexedCore.sv
module tb_icIndexedCore;
  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_PD = 2'd2;
  localparam int NV = 41;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [0:0]  cpuSel = '0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wData = '0;
  logic [31:0] rData;
  logic [11:0] sharedPend = '0;
  logic [7:0]  privPend = '0;
  logic [1:0]  irqOut;
  logic [1:0]  fiqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  icIndexedCore dut (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .addr(addr), .wrEn(wrEn),
    .wData(wData), .rData(rData), .sharedPend(sharedPend), .privPend(privPend),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // row: op, cpu, addr, data (write data / expected read / pending pattern), requirement
  localparam logic [50:0] VEC [NV] = '{
    {OP_RD, 1'b0, 12'h000, 32'h040,   4'd2},   // R2 count, off
    {OP_RD, 1'b0, 12'h044, 32'h3FF,   4'd1},   // R1 nothing claimable
    {OP_RD, 1'b0, 12'h114, 32'h000,   4'd1},   // R1 routing cleared
    {OP_WR, 1'b0, 12'h000, 32'h001,   4'd2},
    {OP_RD, 1'b0, 12'h000, 32'h041,   4'd2},   // R2 on bit
    {OP_PD, 1'b0, 12'h000, 32'h00022, 4'd6},   // sources 5 and 9 pending
    {OP_WR, 1'b0, 12'h114, 32'h001,   4'd5},
    {OP_WR, 1'b0, 12'h124, 32'h003,   4'd5},
    {OP_WR, 1'b0, 12'h030, 32'h005,   4'd3},
    {OP_RD, 1'b0, 12'h044, 32'h3FF,   4'd4},   // R4 still masked
    {OP_WR, 1'b0, 12'h04C, 32'h005,   4'd4},
    {OP_RD, 1'b0, 12'h044, 32'h005,   4'd6},   // R6
    {OP_WR, 1'b0, 12'h030, 32'h009,   4'd3},
    {OP_WR, 1'b0, 12'h04C, 32'h009,   4'd4},
    {OP_RD, 1'b0, 12'h044, 32'h005,   4'd6},   // R6 lowest wins
    {OP_WR, 1'b0, 12'h034, 32'h005,   4'd3},
    {OP_RD, 1'b0, 12'h044, 32'h009,   4'd3},   // R3 disable one only
    {OP_RD, 1'b1, 12'h044, 32'h3FF,   4'd4},   // R4 other cpu masked
    {OP_WR, 1'b1, 12'h04C, 32'h009,   4'd4},
    {OP_RD, 1'b1, 12'h044, 32'h009,   4'd4},
    {OP_WR, 1'b0, 12'h048, 32'h009,   4'd4},
    {OP_RD, 1'b0, 12'h044, 32'h3FF,   4'd4},   // R4 masked on cpu0
    {OP_RD, 1'b1, 12'h044, 32'h009,   4'd4},   // R4 cpu1 unaffected
    {OP_WR, 1'b0, 12'h034, 32'h019,   4'd10},  // index 25 ignored
    {OP_RD, 1'b1, 12'h044, 32'h009,   4'd10},  // R10
    {OP_WR, 1'b1, 12'h048, 32'h019,   4'd10},
    {OP_RD, 1'b1, 12'h044, 32'h009,   4'd10},  // R10
    {OP_RD, 1'b0, 12'h124, 32'h003,   4'd5},   // R5 readback
    {OP_RD, 1'b0, 12'h114, 32'h001,   4'd5},
    {OP_PD, 1'b0, 12'h000, 32'h40022, 4'd9},   // cpu1 private source 2
    {OP_WR, 1'b0, 12'h108, 32'h002,   4'd5},
    {OP_WR, 1'b0, 12'h030, 32'h002,   4'd3},
    {OP_WR, 1'b1, 12'h04C, 32'h002,   4'd4},
    {OP_RD, 1'b1, 12'h044, 32'h002,   4'd9},   // R9 private claim
    {OP_RD, 1'b0, 12'h044, 32'h3FF,   4'd9},   // R9 not pending on cpu0
    {OP_RD, 1'b1, 12'h010, 32'h004,   4'd9},   // R9 cause
    {OP_RD, 1'b0, 12'h010, 32'h000,   4'd9},
    {OP_WR, 1'b1, 12'h040, 32'h00F,   4'd11},
    {OP_RD, 1'b1, 12'h040, 32'h00F,   4'd11},  // R11
    {OP_RD, 1'b0, 12'h040, 32'h000,   4'd11},
    {OP_RD, 1'b1, 12'h044, 32'h002,   4'd11}   // R11 no effect on claim
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cpuSel = c; addr = a; wData = d; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rd(input logic c, input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    cpuSel = c; addr = a; wrEn = 1'b0;
    #5 v = rData;
  endtask

  task automatic settle();
    @(negedge clk);
    #5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    settle();
    check("R1 irqOut", {30'b0, irqOut}, 32'h0);
    check("R1 fiqOut", {30'b0, fiqOut}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic        c;
      logic [11:0] a;
      logic [31:0] d;
      logic [3:0]  r;
      {op, c, a, d, r} = VEC[i];
      if (op == OP_WR) wr(c, a, d);
      else if (op == OP_PD) begin
        @(negedge clk);
        sharedPend = d[11:0];
        privPend   = d[19:12];
      end else begin
        rd(c, a, v);
        check($sformatf("R%0d row %0d", r, i), v, d);
      end
    end

    // R7: cpu0 has no claim, cpu1 claims source 2
    settle();
    check("R7 irqOut", {30'b0, irqOut}, 32'h2);
    check("R8 fiqOut none routed", {30'b0, fiqOut}, 32'h0);
    // R8: source 9 routed to cpu0 FIQ but masked there
    wr(1'b0, 12'h124, 32'h103);
    settle();
    check("R8 fiq masked", {30'b0, fiqOut}, 32'h0);
    wr(1'b0, 12'h04C, 32'h009);
    settle();
    check("R8 fiq unmasked", {30'b0, fiqOut}, 32'h1);
    check("R7 irq both", {30'b0, irqOut}, 32'h3);
    rd(1'b0, 12'h044, v);
    check("R6 cpu0 claim", v, 32'h009);
    // R2: controller off
    wr(1'b0, 12'h000, 32'h000);
    settle();
    check("R2 irq off", {30'b0, irqOut}, 32'h0);
    check("R2 fiq off", {30'b0, fiqOut}, 32'h0);
    rd(1'b1, 12'h044, v);
    check("R2 claim off", v, 32'h3FF);
    // R1: reset clears enables, masks and priority
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    wr(1'b0, 12'h000, 32'h001);
    rd(1'b1, 12'h044, v);
    check("R1 claim after reset", v, 32'h3FF);
    check("R1 irq after reset", {30'b0, irqOut}, 32'h0);
    rd(1'b1, 12'h040, v);
    check("R1 prio after reset", v, 32'h0);
    rd(1'b0, 12'h124, v);
    check("R1 route after reset", v, 32'h0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule